// File: doc/BRIEF.md
# Busy-Gated SPI Command Sequencer

This block drives the command port of a radio transceiver as an SPI master. A host presents a command on a valid/ready port: an opcode byte and a parameter count of 0 to 16. Before that, it loads the parameter bytes into a small local byte buffer. The sequencer waits for the device's BUSY line to be low. It selects the device with an active-low chip select and shifts out the opcode and then the parameter bytes in index order. As each parameter byte goes out, the byte the device returns on MISO replaces it in its buffer slot. When the last byte is done, chip select is released and a one-cycle done pulse follows. The host then reads the returned bytes through the buffer port.

The block tracks whether the device has been put to sleep by a sleep command (opcode 0x84). A sleeping device wakes only when it is selected, so the next transaction reverses the usual order. Chip select drops first, the block waits for BUSY to fall, and the sleep flag clears before any clock edge. A BUSY wait that lasts longer than a programmable number of cycles aborts the transaction and sets an error flag.

Back-pressure: `cmd_ready` is high only when the block is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A request held while `cmd_ready` is low waits. Host buffer writes are accepted only while `cmd_ready` is high.

Top module: `radio_cmd_seq`

## Requirements
- R1: When the device is not flagged asleep, `spi_cs_n` falls only after `dev_busy` was sampled low, and no SCK rising edge occurs while `dev_busy` is high.
- R2: When the device is flagged asleep, `spi_cs_n` falls at command acceptance even with `dev_busy` high. SCK stays idle until `dev_busy` is low. `dev_asleep` clears during that wait, with chip select low.
- R3: Each transaction sends exactly 1 + count bytes on MOSI: the opcode first, then parameter bytes in buffer index order 0, 1, ... count-1. Counts above 16 are treated as 16.
- R4: After a transaction, buffer slot k (k < count) holds the byte received on MISO while parameter k was sent. Slots at or above count are unchanged.
- R5: `spi_cs_n` goes high after the last byte, and `done` is high for exactly one cycle: the first cycle in which chip select is high again.
- R6: `dev_asleep` becomes 1 only on completion of a transaction whose opcode is 0x84. Any other completed opcode leaves it at 0.
- R7: SPI mode 0, MSB first. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge.
- R8: `cmd_ready` is 1 only when idle, including after reset. While it is 0, host buffer writes are ignored.
- R9: If `dev_busy` stays high for `busy_limit` consecutive wait cycles, the block aborts without any SCK edge. It releases `spi_cs_n`, sets `timeout_err` and pulses `done`. The next accepted command clears `timeout_err`.
- R10: Because parameters go out in index order, a register write frame (opcode 0x0D, count 2 + data length, address high byte first, data most significant first) is sent byte for byte. A register read frame (opcode 0x1D, count 3 + data length) returns its data from slot 3 onward, most significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_opcode | input | 8 | Opcode byte of the command |
| cmd_count | input | 5 | Number of parameter bytes (0..16) |
| busy_limit | input | 16 | BUSY wait limit in clock cycles |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last transaction aborted on BUSY wait |
| dev_asleep | output | 1 | Device flagged as sleeping |
| buf_we | input | 1 | Host write strobe to parameter buffer |
| buf_addr | input | 4 | Host buffer index |
| buf_wdata | input | 8 | Host write byte |
| buf_rdata | output | 8 | Buffer byte at `buf_addr` |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | 1 | Active-low chip select |
| dev_busy | input | 1 | Device BUSY line |

## Verification
The bench models the device and holds BUSY high across command acceptance. It checks which way chip select and the BUSY release are ordered. A design that ignores the sleep flag would wait with chip select high and never wake the device. A design that selects early when awake would drop chip select while BUSY is still high. Counts of 0 and 16 probe the byte counter: an off-by-one sends one byte too many or too few, and the scoreboard reports it as a missing or extra byte. The timeout case holds BUSY high forever and expects an abort with no clock edges. A host write during a transfer must leave its buffer slot unchanged, which exposes a missing gate on the buffer port.

// File: rtl/radio_cmd_pkg.sv
package radio_cmd_pkg;
  localparam logic [7:0] OP_SLEEP = 8'h84;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_AWAKE,
    S_WAIT_WAKE,
    S_SHIFT,
    S_FINISH
  } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg;

  wire half_tick = (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      sck       <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        shreg   <= tx_byte;
        div_cnt <= '0;
        bit_cnt <= '0;
        sck     <= 1'b0;
      end else if (active) begin
        if (half_tick) begin
          div_cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + DW'(1);
        end
      end
    end
  end

  assign mosi = active ? shreg[7] : 1'b0;

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);
  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> (!sck || $stable(mosi)));
endmodule

// File: rtl/busy_wait_timer.sv
module busy_wait_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);
  logic [LIM_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clear)                     cnt <= '0;
    else if (count_en && (cnt != '1))   cnt <= cnt + LIM_W'(1);
  end

  assign expired = count_en &&
                   (({1'b0, cnt} + (LIM_W+1)'(1)) >= {1'b0, limit});
endmodule

// File: rtl/cmd_param_buf.sv
module cmd_param_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_waddr,
  input  logic [7:0]    seq_wdata,
  input  logic [AW-1:0] seq_raddr,
  output logic [7:0]    seq_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (seq_we && (seq_waddr == AW'(i)))        mem[i] <= seq_wdata;
        else if (host_we && (host_addr == AW'(i)))  mem[i] <= host_wdata;
      end
    end
  end

  assign host_rdata = mem[host_addr];
  assign seq_rdata  = mem[seq_raddr];
endmodule

// File: rtl/radio_cmd_seq.sv
module radio_cmd_seq
  import radio_cmd_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int MAX_PARAMS = 16,
  parameter int LIM_W      = 16,
  localparam int CW = $clog2(MAX_PARAMS + 1),
  localparam int AW = $clog2(MAX_PARAMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_opcode,
  input  logic [CW-1:0]    cmd_count,
  input  logic [LIM_W-1:0] busy_limit,
  output logic             done,
  output logic             timeout_err,
  output logic             dev_asleep,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       buf_rdata,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n,
  input  logic             dev_busy
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PARAMS);

  seq_state_e    state;
  logic [7:0]    op_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic          cs_n_q;
  logic          asleep_q;
  logic          err_q;

  logic          shift_start;
  logic          byte_done;
  logic [7:0]    rx_byte;
  logic [7:0]    tx_byte;
  logic [7:0]    seq_rdata;
  logic [CW-1:0] tx_idx;
  logic          wait_state;
  logic          expired;
  logic          last_byte;

  wire [CW-1:0] cnt_clamped = (cmd_count > CNT_MAX) ? CNT_MAX : cmd_count;

  assign wait_state = (state == S_WAIT_AWAKE) || (state == S_WAIT_WAKE);
  assign last_byte  = (idx == cnt_q);
  assign tx_idx     = (state == S_SHIFT) ? (idx + CW'(1)) : '0;
  assign tx_byte    = (tx_idx == '0) ? op_q : seq_rdata;

  assign shift_start = (wait_state && !dev_busy) ||
                       ((state == S_SHIFT) && byte_done && !last_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      cnt_q    <= '0;
      idx      <= '0;
      cs_n_q   <= 1'b1;
      asleep_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q  <= cmd_opcode;
            cnt_q <= cnt_clamped;
            idx   <= '0;
            err_q <= 1'b0;
            if (asleep_q) begin
              cs_n_q <= 1'b0;
              state  <= S_WAIT_WAKE;
            end else begin
              state  <= S_WAIT_AWAKE;
            end
          end
        end
        S_WAIT_AWAKE: begin
          if (!dev_busy) begin
            cs_n_q <= 1'b0;
            state  <= S_SHIFT;
          end else if (expired) begin
            err_q <= 1'b1;
            state <= S_FINISH;
          end
        end
        S_WAIT_WAKE: begin
          if (!dev_busy) begin
            asleep_q <= 1'b0;
            state    <= S_SHIFT;
          end else if (expired) begin
            cs_n_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= S_FINISH;
          end
        end
        S_SHIFT: begin
          if (byte_done) begin
            if (last_byte) begin
              cs_n_q <= 1'b1;
              if (op_q == OP_SLEEP) asleep_q <= 1'b1;
              state <= S_FINISH;
            end else begin
              idx <= idx + CW'(1);
            end
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (shift_start),
    .tx_byte   (tx_byte),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  busy_wait_timer #(.LIM_W(LIM_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == S_IDLE),
    .count_en (wait_state && dev_busy),
    .limit    (busy_limit),
    .expired  (expired)
  );

  cmd_param_buf #(.DEPTH(MAX_PARAMS), .AW(AW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (buf_we && cmd_ready),
    .host_addr  (buf_addr),
    .host_wdata (buf_wdata),
    .host_rdata (buf_rdata),
    .seq_we     ((state == S_SHIFT) && byte_done && (idx != '0)),
    .seq_waddr  (AW'(idx - CW'(1))),
    .seq_wdata  (rx_byte),
    .seq_raddr  (AW'(tx_idx - CW'(1))),
    .seq_rdata  (seq_rdata)
  );

  assign cmd_ready   = (state == S_IDLE);
  assign done        = (state == S_FINISH);
  assign timeout_err = err_q;
  assign dev_asleep  = asleep_q;
  assign spi_cs_n    = cs_n_q;

  // R1
  awake_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && !$past(asleep_q)) |-> !$past(dev_busy));
  // R2
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_q) |-> !spi_cs_n);
  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |-> (idx <= cnt_q));
  // R5
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  sleep_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_q) |-> (op_q == OP_SLEEP));
  // R7
  sck_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready);
  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> spi_cs_n);
endmodule

// File: tb/radio_cmd_seq_tb.sv
module radio_cmd_seq_tb;
  typedef logic [7:0] bytes16_t [16];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = '0;
  logic [4:0]  cmd_count = '0;
  logic [15:0] busy_limit = 16'd1000;
  logic        done, timeout_err, dev_asleep;
  logic        buf_we = 1'b0;
  logic [3:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0;
  logic [7:0]  buf_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;
  logic        dev_busy = 1'b0;

  always #5 clk = ~clk;

  radio_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_count(cmd_count), .busy_limit(busy_limit),
    .done(done), .timeout_err(timeout_err), .dev_asleep(dev_asleep),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .dev_busy(dev_busy)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input logic [7:0] s, input int i);
    return 8'h3C ^ s ^ 8'(i * 29);
  endfunction

  // Scoreboard queue and device model
  logic [7:0] expq [$];
  logic [7:0] seed = '0;
  logic [7:0] s_tx = '0, s_rx = '0, e_b;
  int  nbit = 0, bidx = 0, bytes_seen = 0;
  bit  exp_sleep_order = 0;
  bit  sck_busy = 0;

  always @(negedge spi_cs_n) begin
    nbit = 0; bidx = 0;
    s_tx = resp(seed, 0);
    spi_miso = s_tx[7];
    if (exp_sleep_order) check(dev_busy == 1'b1, "R2", "select while still busy", dev_busy, 1);
    else                 check(dev_busy == 1'b0, "R1", "select only after busy low", dev_busy, 0);
  end

  always @(posedge spi_sck) begin
    if (dev_busy) sck_busy = 1;
    s_rx = {s_rx[6:0], spi_mosi};
    nbit++;
    if (nbit == 8) begin
      if (expq.size() == 0) check(0, "R3", "extra byte on MOSI", s_rx, 0);
      else begin
        e_b = expq.pop_front();
        check(s_rx == e_b, "R7", "MSB-first byte on MOSI", s_rx, e_b);
      end
      nbit = 0; bidx++; bytes_seen++;
      s_tx = resp(seed, bidx);
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n) begin
      if (nbit != 0) s_tx = {s_tx[6:0], 1'b0};
      spi_miso = s_tx[7];
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = 4'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    buf_addr = 4'(a);
    #1;
    d = buf_rdata;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Driver: loads params, pushes expected bytes, issues command, checks end state
  task automatic run_cmd(input logic [7:0] op, input int cnt, input bytes16_t pv,
                         input int busy_cyc, input logic [7:0] sd, input bit poke,
                         output bytes16_t got);
    int n;
    logic [7:0] r;
    for (int k = 0; k < cnt; k++) host_write(k, pv[k]);
    if (poke) host_write(15, 8'h11);
    seed = sd;
    @(negedge clk);
    exp_sleep_order = dev_asleep;
    sck_busy = 0;
    bytes_seen = 0;
    expq.push_back(op);
    for (int k = 0; k < cnt; k++) expq.push_back(pv[k]);
    dev_busy = (busy_cyc > 0);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_count = 5'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R8", "ready low while working", cmd_ready, 0);
    if (poke) begin
      buf_we = 1'b1; buf_addr = 4'd15; buf_wdata = 8'h5A;
      @(negedge clk);
      buf_we = 1'b0;
    end
    if (exp_sleep_order) begin
      check(spi_cs_n == 1'b0, "R2", "select at acceptance when asleep", spi_cs_n, 0);
    end
    repeat (busy_cyc) @(negedge clk);
    dev_busy = 1'b0;
    wait_done(n);
    check(done == 1'b1, "R5", "done pulse seen", done, 1);
    check(spi_cs_n == 1'b1, "R5", "cs released at done", spi_cs_n, 1);
    check(sck_busy == 0, "R1", "no sck while busy", sck_busy, 0);
    check(bytes_seen == cnt + 1, "R3", "byte count", bytes_seen, cnt + 1);
    check(expq.size() == 0, "R3", "all expected bytes sent", expq.size(), 0);
    expq.delete();
    @(negedge clk);
    check(done == 1'b0, "R5", "done one cycle", done, 0);
    check(cmd_ready == 1'b1, "R8", "ready after done", cmd_ready, 1);
    check(spi_sck == 1'b0, "R7", "sck idle low", spi_sck, 0);
    for (int k = 0; k < 16; k++) begin
      host_read(k, r);
      got[k] = r;
      if (k < cnt) check(r == resp(sd, k + 1), "R4", "returned byte in slot", r, resp(sd, k + 1));
    end
    if (poke) begin
      host_read(15, r);
      check(r == 8'h11, "R8", "host write ignored while busy", r, 8'h11);
    end
  endtask

  initial begin
    bytes16_t pv, got;
    int n;
    for (int k = 0; k < 16; k++) pv[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8", "reset ready", cmd_ready, 1);
    check(spi_cs_n == 1'b1, "R5", "reset cs high", spi_cs_n, 1);
    check(spi_sck == 1'b0, "R7", "reset sck low", spi_sck, 0);
    check(done == 1'b0, "R5", "reset done low", done, 0);
    check(dev_asleep == 1'b0, "R6", "reset awake", dev_asleep, 0);
    check(timeout_err == 1'b0, "R9", "reset no error", timeout_err, 0);

    // Two params, busy held 5 cycles, host poke during transfer
    pv[0] = 8'h0E; pv[1] = 8'h04;
    run_cmd(8'h8E, 2, pv, 5, 8'h21, 1, got);
    check(dev_asleep == 1'b0, "R6", "non-sleep opcode keeps awake", dev_asleep, 0);

    // Count zero: opcode only
    run_cmd(8'hC0, 0, pv, 0, 8'h42, 0, got);

    // Count sixteen
    for (int k = 0; k < 16; k++) pv[k] = 8'(k * 7 + 1);
    run_cmd(8'h1E, 16, pv, 2, 8'h99, 0, got);

    // Register write frame R10
    pv[0] = 8'h08; pv[1] = 8'hE7; pv[2] = 8'h38; pv[3] = 8'h12;
    run_cmd(8'h0D, 4, pv, 0, 8'h05, 0, got);

    // Register read frame R10: two data bytes at slot 3
    pv[0] = 8'h07; pv[1] = 8'h40; pv[2] = 8'h00; pv[3] = 8'h00; pv[4] = 8'h00;
    run_cmd(8'h1D, 5, pv, 1, 8'h77, 0, got);
    check({got[3], got[4]} == {resp(8'h77, 4), resp(8'h77, 5)}, "R10",
          "register read value", {got[3], got[4]}, {resp(8'h77, 4), resp(8'h77, 5)});

    // Sleep command
    pv[0] = 8'h04;
    run_cmd(8'h84, 1, pv, 3, 8'h10, 0, got);
    check(dev_asleep == 1'b1, "R6", "asleep after 0x84", dev_asleep, 1);

    // Wake-up transaction: select first, then busy drops
    run_cmd(8'hC0, 0, pv, 12, 8'h33, 0, got);
    check(dev_asleep == 1'b0, "R2", "asleep cleared by wake", dev_asleep, 0);

    // BUSY timeout
    busy_limit = 16'd20;
    bytes_seen = 0;
    @(negedge clk);
    dev_busy = 1'b1;
    cmd_valid = 1'b1; cmd_opcode = 8'h80; cmd_count = 5'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(n);
    check(done == 1'b1, "R9", "abort pulses done", done, 1);
    check(n >= 15 && n <= 30, "R9", "abort latency", n, 20);
    check(timeout_err == 1'b1, "R9", "timeout flag set", timeout_err, 1);
    check(spi_cs_n == 1'b1, "R9", "cs high after abort", spi_cs_n, 1);
    check(bytes_seen == 0, "R9", "no bytes on abort", bytes_seen, 0);
    dev_busy = 1'b0;
    expq.delete();
    busy_limit = 16'd1000;
    @(negedge clk);

    // Next command clears the error
    pv[0] = 8'hA5;
    run_cmd(8'h8A, 1, pv, 0, 8'h6C, 0, got);
    check(timeout_err == 1'b0, "R9", "flag cleared by next command", timeout_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule